// File: doc/BRIEF.md
# Register Block Transfer Sequencer

This block copies a contiguous group of 8-bit general registers to byte-addressed memory, or fills such a group from memory, starting at the address held in the 16-bit index register. A single start strobe, along with the transfer mode and the two register numbers taken from the instruction, launches a transfer. The sequencer then moves one byte per clock. It reads the register file through a combinational read port and writes it through a write port. The memory is synchronous and returns read data one cycle after the read request.

There are two addressing forms. The prefix form covers registers 0 through X. When it finishes, it hands back a new index value equal to the old index plus X+1. The range form covers the registers from X to Y and never updates the index. If X is above Y, the registers are visited in descending order, but memory addresses still rise by one per step. The memory side has a fixed latency and no back-pressure: the sequencer issues a request on every busy cycle, and the attached memory must accept it in that cycle.

Top module: `regblk_xfer`

## Requirements
- R1: A start strobe is accepted only while busy_o is low. A strobe seen while busy is ignored, and the running transfer completes unchanged.
- R2: Mode 0 (prefix store) writes register k to address I+k for k = 0..X, one write per cycle, beginning in the cycle after the accepting edge.
- R3: Mode 1 (prefix load) reads address I+k for k = 0..X. Register k is written with the returned byte in the cycle after its read.
- R4: In the prefix modes (0 and 1), idx_we_o is high in the done cycle and idx_o equals I+X+1 modulo 65536.
- R5: Mode 2 (range store) with X <= Y writes registers X..Y in ascending order to addresses I, I+1, and so on.
- R6: Mode 3 (range load) with X <= Y fills registers X..Y in ascending order from addresses I, I+1, and so on.
- R7: In the range modes with X > Y, registers X down to Y are transferred in descending order while the addresses still ascend from I.
- R8: In the range modes (2 and 3), idx_we_o is never asserted.
- R9: done_o is a one-cycle pulse that appears exactly N clock edges after the accepting edge, where N is the number of registers moved. busy_o stays high from the accepting edge through the done cycle.
- R10: Memory addresses and the updated index wrap modulo 65536.
- R11: mem_we_o and mem_re_o are never high together, and neither is high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, sampled only while idle |
| mode_i | input | 2 | Bit 0: load (1) or store (0); bit 1: range form (1) or prefix form (0) |
| x_i | input | 4 | First register number |
| y_i | input | 4 | Last register number in the range form |
| idx_i | input | 16 | Current index value |
| mem_addr_o | output | 16 | Memory byte address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_re_o | output | 1 | Memory read request |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after mem_re_o |
| rf_raddr_o | output | 4 | Register file read address |
| rf_rdata_i | input | 8 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 4 | Register file write address |
| rf_wdata_o | output | 8 | Register file write data |
| idx_we_o | output | 1 | Index write enable |
| idx_o | output | 16 | Updated index value |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Counting from the edge that accepts start, step k drives its memory address and write strobe after edge k. A load's register write follows one edge later. done_o and the index update appear after edge N. The bench checks the full 16-bit address on the falling edge that follows each rising edge. It requires done_o on exactly the Nth falling edge, and it compares memory and register contents against the bench's own model only after the done cycle, once every write has landed. A start pulse injected mid-transfer shows up as changed contents or a shifted done cycle if the block wrongly accepts it.

// File: rtl/regblk_pkg.sv
package regblk_pkg;
  typedef enum logic [1:0] {
    XF_ST_PFX = 2'd0,
    XF_LD_PFX = 2'd1,
    XF_ST_RNG = 2'd2,
    XF_LD_RNG = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIN  = 2'd2
  } phase_e;
endpackage

// File: rtl/regblk_seq.sv
module regblk_seq #(
  parameter int AW  = 16,
  parameter int RIW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  regblk_pkg::xfer_mode_e mode_i,
  input  logic [RIW-1:0]         x_i,
  input  logic [RIW-1:0]         y_i,
  input  logic [AW-1:0]          idx_i,
  output logic                   run_o,
  output logic                   fin_o,
  output logic                   busy_o,
  output logic [RIW-1:0]         step_o,
  output regblk_pkg::xfer_mode_e mode_o,
  output logic [RIW-1:0]         x_o,
  output logic                   desc_o,
  output logic [AW-1:0]          base_o
);
  import regblk_pkg::*;

  phase_e         ph_q;
  logic [RIW-1:0] step_q, last_q, x_q;
  logic           desc_q;
  logic [AW-1:0]  base_q;
  xfer_mode_e     mode_q;
  logic           take;
  logic [RIW-1:0] span;

  assign take = start_i && (ph_q == PH_IDLE);

  always_comb begin
    if (!mode_i[1])      span = x_i;
    else if (x_i > y_i)  span = x_i - y_i;
    else                 span = y_i - x_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      step_q <= '0;
      last_q <= '0;
      x_q    <= '0;
      desc_q <= 1'b0;
      base_q <= '0;
      mode_q <= XF_ST_PFX;
    end else begin
      case (ph_q)
        PH_IDLE: if (take) begin
          ph_q   <= PH_RUN;
          step_q <= '0;
          last_q <= span;
          x_q    <= x_i;
          desc_q <= mode_i[1] && (x_i > y_i);
          base_q <= idx_i;
          mode_q <= mode_i;
        end
        PH_RUN: begin
          if (step_q == last_q) ph_q <= PH_FIN;
          else                  step_q <= step_q + 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign run_o  = (ph_q == PH_RUN);
  assign fin_o  = (ph_q == PH_FIN);
  assign busy_o = (ph_q != PH_IDLE);
  assign step_o = step_q;
  assign mode_o = mode_q;
  assign x_o    = x_q;
  assign desc_o = desc_q;
  assign base_o = base_q;

  // R1: captured transfer fields hold for the whole run
  a_r1_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |=> ($stable(base_q) && $stable(mode_q) && $stable(x_q)));

  // R9: done pulse lasts one cycle
  a_r9_fin_single: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !fin_o);
endmodule

// File: rtl/regblk_map.sv
module regblk_map #(
  parameter int AW  = 16,
  parameter int RIW = 4
) (
  input  logic [AW-1:0]  base_i,
  input  logic [RIW-1:0] step_i,
  input  logic [RIW-1:0] x_i,
  input  logic           range_i,
  input  logic           desc_i,
  output logic [AW-1:0]  addr_o,
  output logic [RIW-1:0] reg_o,
  output logic [AW-1:0]  idx_next_o
);
  assign addr_o     = base_i + AW'(step_i);
  assign idx_next_o = base_i + AW'(x_i) + AW'(1);

  always_comb begin
    if (!range_i)    reg_o = step_i;
    else if (desc_i) reg_o = x_i - step_i;
    else             reg_o = x_i + step_i;
  end
endmodule

// File: rtl/regblk_xfer.sv
module regblk_xfer #(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int NREG = 16,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [1:0]     mode_i,
  input  logic [RIW-1:0] x_i,
  input  logic [RIW-1:0] y_i,
  input  logic [AW-1:0]  idx_i,
  output logic [AW-1:0]  mem_addr_o,
  output logic           mem_we_o,
  output logic [DW-1:0]  mem_wdata_o,
  output logic           mem_re_o,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic [RIW-1:0] rf_raddr_o,
  input  logic [DW-1:0]  rf_rdata_i,
  output logic           rf_we_o,
  output logic [RIW-1:0] rf_waddr_o,
  output logic [DW-1:0]  rf_wdata_o,
  output logic           idx_we_o,
  output logic [AW-1:0]  idx_o,
  output logic           busy_o,
  output logic           done_o
);
  import regblk_pkg::*;

  logic           run, fin, desc;
  logic [RIW-1:0] step, xq, reg_sel;
  xfer_mode_e     mode_q;
  logic [AW-1:0]  base, addr, idx_next;
  logic           wb_v;
  logic [RIW-1:0] wb_reg;

  regblk_seq #(.AW(AW), .RIW(RIW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .mode_i(xfer_mode_e'(mode_i)), .x_i(x_i), .y_i(y_i), .idx_i(idx_i),
    .run_o(run), .fin_o(fin), .busy_o(busy_o), .step_o(step),
    .mode_o(mode_q), .x_o(xq), .desc_o(desc), .base_o(base)
  );

  regblk_map #(.AW(AW), .RIW(RIW)) u_map (
    .base_i(base), .step_i(step), .x_i(xq), .range_i(mode_q[1]),
    .desc_i(desc), .addr_o(addr), .reg_o(reg_sel), .idx_next_o(idx_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_v   <= 1'b0;
      wb_reg <= '0;
    end else begin
      wb_v   <= run && mode_q[0];
      wb_reg <= reg_sel;
    end
  end

  assign mem_addr_o  = addr;
  assign mem_we_o    = run && !mode_q[0];
  assign mem_re_o    = run && mode_q[0];
  assign mem_wdata_o = rf_rdata_i;
  assign rf_raddr_o  = reg_sel;
  assign rf_we_o     = wb_v;
  assign rf_waddr_o  = wb_reg;
  assign rf_wdata_o  = mem_rdata_i;
  assign done_o      = fin;
  assign idx_we_o    = fin && !mode_q[1];
  assign idx_o       = idx_next;

  // R11: never read and write memory together, and no access while idle
  a_r11_mem_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o) && ((mem_we_o || mem_re_o) -> busy_o));

  // R3: a register write always follows a memory read one cycle earlier
  a_r3_wb_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> $past(mem_re_o));

  // R2 / R10: addresses advance by one per busy cycle, wrapping
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o || mem_re_o) && $past(mem_we_o || mem_re_o)
      |-> mem_addr_o == AW'($past(mem_addr_o) + AW'(1)));

  // R9: busy covers the done cycle
  a_r9_busy_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);
endmodule

// File: tb/regblk_xfer_tb_top.sv
module regblk_xfer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [3:0]  x_i = '0, y_i = '0;
  logic [15:0] idx_i = '0;
  logic [15:0] mem_addr_o;
  logic        mem_we_o, mem_re_o, rf_we_o, idx_we_o, busy_o, done_o;
  logic [7:0]  mem_wdata_o, rf_wdata_o, rf_rdata_i;
  logic [7:0]  mem_rdata_i = '0;
  logic [3:0]  rf_raddr_o, rf_waddr_o;
  logic [15:0] idx_o;

  logic [7:0] mem [256];
  logic [7:0] rf  [16];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  regblk_xfer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .x_i(x_i), .y_i(y_i), .idx_i(idx_i),
    .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
    .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata_i),
    .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .idx_we_o(idx_we_o), .idx_o(idx_o), .busy_o(busy_o), .done_o(done_o)
  );

  assign rf_rdata_i = rf[rf_raddr_o];

  always @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
    if (mem_re_o) mem_rdata_i <= mem[mem_addr_o[7:0]];
    if (rf_we_o)  rf[rf_waddr_o] <= rf_wdata_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int n_of(input logic [1:0] m, input logic [3:0] x, input logic [3:0] y);
    if (!m[1]) return int'(x) + 1;
    return (x > y) ? int'(x - y) + 1 : int'(y - x) + 1;
  endfunction

  function automatic logic [3:0] reg_of(input logic [1:0] m, input logic [3:0] x,
                                         input logic [3:0] y, input int k);
    if (!m[1]) return 4'(k);
    return (x > y) ? 4'(x - 4'(k)) : 4'(x + 4'(k));
  endfunction

  function automatic string req_of(input logic [1:0] m, input logic [3:0] x, input logic [3:0] y);
    if (m[1] && x > y) return "R7";
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run_op(input logic [1:0] m, input logic [3:0] x, input logic [3:0] y,
                        input logic [15:0] base, input bit poke);
    logic [7:0] ms [256];
    logic [7:0] rs [16];
    int n, j;
    bit seen;
    string rq;
    n  = n_of(m, x, y);
    rq = req_of(m, x, y);
    ms = mem;
    rs = rf;
    @(negedge clk);
    start_i = 1'b1; mode_i = m; x_i = x; y_i = y; idx_i = base;
    @(negedge clk);
    start_i = 1'b0;
    j = 0; seen = 1'b0;
    while (!seen && j <= 40) begin
      if (j < n) begin
        chk({rq, "/R10 addr"}, 32'(mem_addr_o), 32'(16'(base + 16'(j))));
        chk("R11 access", 32'({mem_we_o, mem_re_o}), m[0] ? 32'd1 : 32'd2);
      end
      if (poke && j == 1) begin
        start_i = 1'b1; mode_i = ~m; x_i = ~x; y_i = 4'd3; idx_i = ~base;
      end else begin
        start_i = 1'b0;
      end
      if (done_o) begin
        seen = 1'b1;
        chk("R9 done cycle", 32'(j), 32'(n));
        chk(m[1] ? "R8 idx_we" : "R4 idx_we", 32'(idx_we_o), m[1] ? 32'd0 : 32'd1);
        if (!m[1]) chk("R4/R10 idx", 32'(idx_o), 32'(16'(base + 16'(x) + 16'd1)));
        chk("R9 busy in done", 32'(busy_o), 32'd1);
      end else if (m[1] && idx_we_o) begin
        chk("R8 idx_we", 32'(idx_we_o), 32'd0);
      end
      @(negedge clk);
      j++;
    end
    start_i = 1'b0;
    if (!seen) chk("R9 watchdog", 32'(j), 32'(n));
    chk(poke ? "R1 idle after" : "R9 idle after", 32'({busy_o, done_o}), 32'd0);
    for (int k = 0; k < n; k++) begin
      logic [3:0] r;
      logic [7:0] a;
      r = reg_of(m, x, y, k);
      a = 8'(base + 16'(k));
      if (m[0]) chk(rq, 32'(rf[r]), 32'(ms[a]));
      else      chk(rq, 32'(mem[a]), 32'(rs[r]));
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 16; i++)  rf[i]  = 8'($urandom);
    repeat (3) @(negedge clk);
    chk("R11 reset", 32'({busy_o, done_o, mem_we_o, mem_re_o, rf_we_o, idx_we_o}), 32'd0);
    rst_n = 1'b1;
    // directed corners
    run_op(2'd0, 4'd0,  4'd0, 16'h0300, 1'b0);
    run_op(2'd1, 4'd15, 4'd0, 16'hFFF8, 1'b0);
    run_op(2'd0, 4'd15, 4'd0, 16'hFFF4, 1'b0);
    run_op(2'd2, 4'd3,  4'd9, 16'h1000, 1'b0);
    run_op(2'd3, 4'd2,  4'd7, 16'hFFFE, 1'b0);
    run_op(2'd3, 4'd12, 4'd4, 16'h2040, 1'b0);
    run_op(2'd2, 4'd14, 4'd1, 16'h0010, 1'b0);
    run_op(2'd2, 4'd5,  4'd5, 16'h0020, 1'b0);
    run_op(2'd1, 4'd6,  4'd0, 16'h4000, 1'b1);
    run_op(2'd3, 4'd9,  4'd2, 16'h5000, 1'b1);
    // random mix
    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < 16; i++) rf[i] = 8'($urandom);
      run_op(2'($urandom), 4'($urandom), 4'($urandom), 16'($urandom), ($urandom % 4) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule